// File: doc/BRIEF.md
# Edge-Capture Interrupt Aggregator

This block is the interrupt front end of an eight-channel digital input module that sits on a simple register bus. Each input is brought into the clock domain by a synchronizer, and its transitions are detected. A transition in an enabled direction sets a sticky event flag for that channel and direction. The enabled flags merge into a single level interrupt request for the host, and that request stays high as long as any enabled flag is set.

Software selects, per channel, which directions raise events. It reads two event summary registers to see which channels fired, and it retires a channel by reading that channel's own address, which returns and clears both of its flags. A write to the line-release address drops the merged request for a fixed time of about 100 ns, so that a shared edge-triggered host input sees a new rising edge once the request comes back. A second write address clears every flag at once, as an init step.

Top module: `edge_irq_agg`

## Requirements
- R1: After reset all flags and both enable registers are zero, `irqOut` is low and `busRdata` is zero.
- R2: A rising (falling) transition on an input whose rising (falling) enable is set sets that channel's rise (fall) flag. The flag appears as bit i of the rise event register (offset 0x0B) or the fall event register (offset 0x0C), and it stays set whatever the input does afterwards.
- R3: `irqOut` is high exactly when some flag is set together with its enable and no release pulse is running.
- R4: A read at offset n (0..7) returns the fall flag in bit 1 and the rise flag in bit 0 of channel n, with the other bits zero, one cycle later on `busRdata`. The same read clears both flags of channel n.
- R5: If a transition on channel n is detected in the same cycle as a read-clear of channel n, the flag for that transition is set after the read.
- R6: Rise enables live at offset 0x08 and fall enables at offset 0x09, with bit i for channel i, and both can be read back. A flag is set only while its enable is set. Writing 0 over an enable bit that was 1 clears the matching flag.
- R7: A write to offset 0x0D holds `irqOut` low for PULSE_CYC cycles, starting in the cycle after the write. PULSE_CYC is ceil(CLK_KHZ*PULSE_NS/10^6), and is 5 with the default parameters. After that, `irqOut` follows the flags again.
- R8: A write to offset 0x0E clears every flag. This clear wins over a transition in the same cycle, and the enables are kept.
- R9: A read at offset 0x0A returns the synchronized input levels, with bit i for channel i.
- R10: Reading the event registers at 0x0B and 0x0C clears nothing.
- R11: Reads at offsets 0x0D to 0x0F return zero. Writes to read-only offsets change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 8 | Raw digital inputs, asynchronous |
| busAddr | input | 4 | Register offset |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid the cycle after `busRd` |
| irqOut | output | 1 | Merged interrupt request |

## Verification
A new input transition can be detected in the very cycle in which software read-clears the same channel, so two actions hit one flag register in the same clock. The bench provokes this by placing the input change exactly two edges before the read strobe, because the synchronizer has two stages. It then judges the result from what the read returns, which is the old flag, and from the rise event register afterwards, which must still show the new event. The release pulse and the flag state are also exercised together: `irqOut` is sampled in every cycle of the pulse window while a flag remains set.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int CH_COUNT = 8;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 8;
  localparam int CH_IDX_W = $clog2(CH_COUNT);

  localparam logic [ADDR_W-1:0] OFS_RISE_EN  = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_FALL_EN  = 4'h9;
  localparam logic [ADDR_W-1:0] OFS_LEVEL    = 4'hA;
  localparam logic [ADDR_W-1:0] OFS_RISE_EVT = 4'hB;
  localparam logic [ADDR_W-1:0] OFS_FALL_EVT = 4'hC;
  localparam logic [ADDR_W-1:0] OFS_PULSE    = 4'hD;
  localparam logic [ADDR_W-1:0] OFS_INIT     = 4'hE;

  typedef struct packed {
    logic [CH_COUNT-1:0] chClr;
    logic                clrAll;
    logic                riseEnWr;
    logic                fallEnWr;
    logic [DATA_W-1:0]   wrData;
    logic                irqHold;
  } ctl_strobe_t;
endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int CHAIN_W = STAGES * WIDTH;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[CHAIN_W-WIDTH-1:0], din};
  end

  assign dout = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/edge_irq_dp.sv
module edge_irq_dp
  import edge_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [CH_COUNT-1:0] pinIn,
  input  ctl_strobe_t         ctl,
  output logic [CH_COUNT-1:0] level,
  output logic [CH_COUNT-1:0] riseFlag,
  output logic [CH_COUNT-1:0] fallFlag,
  output logic [CH_COUNT-1:0] riseEn,
  output logic [CH_COUNT-1:0] fallEn,
  output logic                irqOut
);
  logic [CH_COUNT-1:0] prevLvl;

  edge_irq_sync #(.WIDTH(CH_COUNT), .STAGES(2)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (pinIn),
    .dout(level)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLvl <= '0;
      riseEn  <= '0;
      fallEn  <= '0;
    end else begin
      prevLvl <= level;
      if (ctl.riseEnWr) riseEn <= ctl.wrData[CH_COUNT-1:0];
      if (ctl.fallEnWr) fallEn <= ctl.wrData[CH_COUNT-1:0];
    end
  end

  for (genvar i = 0; i < CH_COUNT; i++) begin : g_ch
    logic riseEdge, fallEdge, riseDrop, fallDrop;
    assign riseEdge = level[i] & ~prevLvl[i];
    assign fallEdge = ~level[i] & prevLvl[i];
    assign riseDrop = ctl.riseEnWr & riseEn[i] & ~ctl.wrData[i];
    assign fallDrop = ctl.fallEnWr & fallEn[i] & ~ctl.wrData[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        riseFlag[i] <= 1'b0;
        fallFlag[i] <= 1'b0;
      end else begin
        if (ctl.clrAll)                            riseFlag[i] <= 1'b0;
        else if (riseEdge & riseEn[i] & ~riseDrop) riseFlag[i] <= 1'b1;
        else if (ctl.chClr[i] | riseDrop)          riseFlag[i] <= 1'b0;

        if (ctl.clrAll)                            fallFlag[i] <= 1'b0;
        else if (fallEdge & fallEn[i] & ~fallDrop) fallFlag[i] <= 1'b1;
        else if (ctl.chClr[i] | fallDrop)          fallFlag[i] <= 1'b0;
      end
    end
  end

  assign irqOut = (|((riseFlag & riseEn) | (fallFlag & fallEn))) & ~ctl.irqHold;
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int PULSE_CYC = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busRd,
  input  logic                busWr,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic [CH_COUNT-1:0] level,
  input  logic [CH_COUNT-1:0] riseFlag,
  input  logic [CH_COUNT-1:0] fallFlag,
  input  logic [CH_COUNT-1:0] riseEn,
  input  logic [CH_COUNT-1:0] fallEn,
  output ctl_strobe_t         ctl,
  output logic [DATA_W-1:0]   busRdata
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);

  logic [CNT_W-1:0]  holdCnt;
  logic [DATA_W-1:0] rdNext;
  logic              chAddr;
  logic [CH_IDX_W-1:0] chIdx;

  assign chAddr = busAddr < ADDR_W'(CH_COUNT);
  assign chIdx  = busAddr[CH_IDX_W-1:0];

  for (genvar i = 0; i < CH_COUNT; i++) begin : g_clr
    assign ctl.chClr[i] = busRd && (busAddr == ADDR_W'(i));
  end

  assign ctl.clrAll   = busWr && (busAddr == OFS_INIT);
  assign ctl.riseEnWr = busWr && (busAddr == OFS_RISE_EN);
  assign ctl.fallEnWr = busWr && (busAddr == OFS_FALL_EN);
  assign ctl.wrData   = busWdata;
  assign ctl.irqHold  = holdCnt != '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              holdCnt <= '0;
    else if (busWr && busAddr == OFS_PULSE) holdCnt <= CNT_W'(PULSE_CYC);
    else if (holdCnt != '0)                 holdCnt <= holdCnt - 1'b1;
  end

  always_comb begin
    rdNext = '0;
    if (chAddr) begin
      rdNext[0] = riseFlag[chIdx];
      rdNext[1] = fallFlag[chIdx];
    end else begin
      case (busAddr)
        OFS_RISE_EN:  rdNext[CH_COUNT-1:0] = riseEn;
        OFS_FALL_EN:  rdNext[CH_COUNT-1:0] = fallEn;
        OFS_LEVEL:    rdNext[CH_COUNT-1:0] = level;
        OFS_RISE_EVT: rdNext[CH_COUNT-1:0] = riseFlag;
        OFS_FALL_EVT: rdNext[CH_COUNT-1:0] = fallFlag;
        default:      rdNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdata <= '0;
    else       busRdata <= busRd ? rdNext : '0;
  end
endmodule

// File: rtl/edge_irq_agg.sv
module edge_irq_agg
  import edge_irq_pkg::*;
#(
  parameter int CLK_KHZ  = 50000,
  parameter int PULSE_NS = 100
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CH_COUNT-1:0] pinIn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busRd,
  input  logic                busWr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  output logic                irqOut
);
  localparam int PULSE_RAW = (CLK_KHZ * PULSE_NS + 999_999) / 1_000_000;
  localparam int PULSE_CYC = (PULSE_RAW < 1) ? 1 : PULSE_RAW;

  ctl_strobe_t         ctl;
  logic [CH_COUNT-1:0] level, riseFlag, fallFlag, riseEn, fallEn;

  edge_irq_ctrl #(.PULSE_CYC(PULSE_CYC)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .busWdata(busWdata),
    .level   (level),
    .riseFlag(riseFlag),
    .fallFlag(fallFlag),
    .riseEn  (riseEn),
    .fallEn  (fallEn),
    .ctl     (ctl),
    .busRdata(busRdata)
  );

  edge_irq_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .ctl     (ctl),
    .level   (level),
    .riseFlag(riseFlag),
    .fallFlag(fallFlag),
    .riseEn  (riseEn),
    .fallEn  (fallEn),
    .irqOut  (irqOut)
  );
endmodule

// File: rtl/edge_irq_agg_chk.sv
module edge_irq_agg_chk
  import edge_irq_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busRd,
  input logic                busWr,
  input logic [DATA_W-1:0]   busRdata,
  input logic                irqOut,
  input logic [CH_COUNT-1:0] riseFlag,
  input logic [CH_COUNT-1:0] fallFlag,
  input logic [CH_COUNT-1:0] riseEn,
  input logic [CH_COUNT-1:0] fallEn
);
  AST_PULSE_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == OFS_PULSE) |=> !irqOut); // R7

  AST_IRQ_NEEDS_ENABLED_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (((riseFlag & riseEn) | (fallFlag & fallEn)) != '0)); // R3

  AST_FLAG_ONLY_WHEN_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    ((riseFlag & ~riseEn) == '0) && ((fallFlag & ~fallEn) == '0)); // R6

  AST_INIT_CLEARS_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == OFS_INIT) |=> (riseFlag == '0 && fallFlag == '0)); // R8

  AST_UNUSED_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr >= OFS_PULSE) |=> (busRdata == '0)); // R11

  for (genvar i = 0; i < CH_COUNT; i++) begin : g_sticky
    AST_RISE_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (riseFlag[i] && !(busRd && busAddr == ADDR_W'(i))
        && !(busWr && (busAddr == OFS_INIT || busAddr == OFS_RISE_EN)))
      |=> riseFlag[i]); // R2
    AST_FALL_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (fallFlag[i] && !(busRd && busAddr == ADDR_W'(i))
        && !(busWr && (busAddr == OFS_INIT || busAddr == OFS_FALL_EN)))
      |=> fallFlag[i]); // R2
  end
endmodule

bind edge_irq_agg edge_irq_agg_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busAddr (busAddr),
  .busRd   (busRd),
  .busWr   (busWr),
  .busRdata(busRdata),
  .irqOut  (irqOut),
  .riseFlag(riseFlag),
  .fallFlag(fallFlag),
  .riseEn  (riseEn),
  .fallEn  (fallEn)
);

// File: tb/edge_irq_agg_tb.sv
module edge_irq_agg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE_CYC  = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] pinIn = '0;
  logic [3:0] busAddr = '0;
  logic       busRd = 1'b0;
  logic       busWr = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       irqOut;

  int total = 0;
  int bad = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  edge_irq_agg u_dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .busAddr(busAddr),
    .busRd(busRd), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: called at a negedge, pushes expected read data
  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    busAddr <= a; busRd <= 1'b1;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    busRd <= 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    busAddr <= a; busWdata <= d; busWr <= 1'b1;
    @(negedge clk);
    busWr <= 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // monitor: the read strobe seen here was high during the last posedge
  always @(negedge clk) begin
    if (busRd) begin
      if (expQ.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard: actual=%h expected=none", busRdata);
      end else begin
        chk(busRdata, expQ.pop_front(), tagQ.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({7'd0, irqOut}, 8'h00, "R1 irq in reset");
    rstN <= 1'b1;
    @(negedge clk);
    chk({7'd0, irqOut}, 8'h00, "R1 irq after reset");
    chk(busRdata, 8'h00, "R1 rdata after reset");
    rd(4'hB, 8'h00, "R1 rise events");
    rd(4'h8, 8'h00, "R1 rise enables");
    rd(4'hA, 8'h00, "R9 levels low");

    wr(4'h8, 8'h05);
    wr(4'h9, 8'h06);
    rd(4'h8, 8'h05, "R6 rise enable readback");
    rd(4'h9, 8'h06, "R6 fall enable readback");

    pinIn <= 8'h01; settle();
    chk({7'd0, irqOut}, 8'h01, "R3 irq on rise flag");
    rd(4'hB, 8'h01, "R2 rise event ch0");
    rd(4'hB, 8'h01, "R10 event read keeps flag");
    pinIn <= 8'h00; settle();
    rd(4'hC, 8'h00, "R6 fall not enabled ch0");
    rd(4'hB, 8'h01, "R2 flag sticky after input drops");

    pinIn <= 8'hA0; settle();
    rd(4'hA, 8'hA0, "R9 level register");
    pinIn <= 8'h00; settle();

    rd(4'h0, 8'h01, "R4 channel read returns rise");
    chk({7'd0, irqOut}, 8'h00, "R3 irq low after clear");
    rd(4'hB, 8'h00, "R4 channel read cleared flag");

    pinIn <= 8'h04; settle();
    pinIn <= 8'h00; settle();
    rd(4'hB, 8'h04, "R2 rise event ch2");
    rd(4'hC, 8'h04, "R2 fall event ch2");
    rd(4'h2, 8'h03, "R4 both flags ch2");
    rd(4'hC, 8'h00, "R4 fall flag cleared ch2");

    // coincident edge and read-clear on ch0
    pinIn <= 8'h01; settle();
    pinIn <= 8'h00; settle();
    pinIn <= 8'h01;
    @(negedge clk); @(negedge clk);
    rd(4'h0, 8'h01, "R5 read returns old flag");
    settle();
    rd(4'hB, 8'h01, "R5 new edge kept over clear");
    chk({7'd0, irqOut}, 8'h01, "R3 irq still high");

    wr(4'hD, 8'h00);
    for (int k = 0; k < PULSE_CYC; k++) begin
      chk({7'd0, irqOut}, 8'h00, "R7 irq held low");
      @(negedge clk);
    end
    chk({7'd0, irqOut}, 8'h01, "R7 irq returns after pulse");

    wr(4'h8, 8'h04);
    rd(4'hB, 8'h00, "R6 disabling clears flag");
    chk({7'd0, irqOut}, 8'h00, "R6 irq low after disable");

    pinIn <= 8'h03; settle();
    pinIn <= 8'h05; settle();
    rd(4'hC, 8'h02, "R2 fall event ch1");
    rd(4'hB, 8'h04, "R2 rise event ch2 again");
    wr(4'hE, 8'h00);
    rd(4'hB, 8'h00, "R8 rise flags cleared");
    rd(4'hC, 8'h00, "R8 fall flags cleared");
    chk({7'd0, irqOut}, 8'h00, "R8 irq low");
    rd(4'h8, 8'h04, "R8 enables kept");

    rd(4'hF, 8'h00, "R11 unused read");
    rd(4'hD, 8'h00, "R11 pulse read");
    wr(4'hA, 8'hFF);
    wr(4'hB, 8'hFF);
    rd(4'h8, 8'h04, "R11 write ro keeps rise en");
    rd(4'h9, 8'h06, "R11 write ro keeps fall en");
    rd(4'hB, 8'h00, "R11 write ro keeps flags");

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", expQ.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule